// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. Characters queue in an eight-entry transmit FIFO and are shifted out on a single line. Incoming frames are sampled at sixteen times the bit rate and land in an eight-entry receive FIFO. Each entry in that FIFO carries its own parity and framing error bits. The bit rate comes from a divisor field: one bit lasts 16*(divisor+1) clock cycles. Frames can use no parity, even parity or odd parity, and one or two stop bits.

Surrounding logic sets the configuration fields and writes characters with a one-cycle push strobe. It reads the receive head combinationally and removes the head with a pop strobe. Three registered interrupt lines report faults, received data and transmit progress; two select fields set when the receive and transmit lines fire. An internal loopback path routes the transmitter into the receiver, and a break control holds the line low. Dropping the enable flushes both FIFOs and returns both shift engines to idle.

Top module: `uart_fifo_core`

## Requirements
- R1: After reset, and while no character is being sent, `serial_tx` is 1, `tx_empty` is 1, and `tx_full`, `rx_avail`, `rx_overrun` and all three interrupts are 0.
- R2: A frame is one low start bit, then 8 data bits least significant first, then the optional parity bit, then one stop bit (`cfg_two_stop`=0) or two stop bits (`cfg_two_stop`=1) at level 1. Every bit lasts 16*(`cfg_divisor`+1) cycles, and queued characters follow one another with no idle gap.
- R3: `cfg_parity` 2'b00 means no parity bit, 2'b01 means even parity (bit = XOR of the data), 2'b10 means odd parity (bit = inverted XOR). The value 2'b11 acts as no parity.
- R4: The transmit FIFO holds 8 characters. `tx_full` is 1 while it holds 8, and a push while full is discarded.
- R5: `tx_empty` is 1 only when the transmit FIFO is empty and the shifter is idle. It stays 0 while the last character is still being shifted out.
- R6: `rx_avail` is 1 while the receive FIFO holds at least one character. `rx_data` shows the oldest one, and `rx_pop` removes it, so characters come out in arrival order.
- R7: A character that completes while the receive FIFO holds 8 is dropped and sets `rx_overrun`. The flag stays set until a one-cycle `ovr_clear` pulse, which also empties the receive FIFO. `irq_fault` is 1 while `rx_overrun` is 1.
- R8: `rx_par_err` and `rx_frm_err` describe the character at the receive head. A framing error is a stop bit sampled low. `irq_fault` is also 1 while the head has either error.
- R9: With `cfg_loopback`=1 the receiver takes the transmitter's own line, and `serial_rx` is ignored.
- R10: While `cfg_on` and `cfg_break` are both 1, `serial_tx` is 0 from the next cycle on.
- R11: `irq_rx` is 1 when the receive FIFO holds at least 1 entry (`cfg_rx_isel`=00), at least 4 entries (01), or 8 entries (1x).
- R12: `irq_tx` is 1 when the transmit FIFO is not full (`cfg_tx_isel`=00), when `tx_empty` is 1 (01), or when the transmit FIFO is empty even if the shifter is still busy (1x).
- R13: While `cfg_on` is 0, both FIFOs are flushed, both engines are idle, `serial_tx` is 1 and all interrupts are 0.
- R14: With `cfg_tx_en`=0 no new frame starts and queued characters wait. With `cfg_rx_en`=0, received characters are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_on | input | 1 | Block enable; 0 flushes and idles |
| cfg_tx_en | input | 1 | Allows new frames to start |
| cfg_rx_en | input | 1 | Allows received characters into the FIFO |
| cfg_parity | input | 2 | Parity mode (R3) |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_loopback | input | 1 | Internal transmit-to-receive path |
| cfg_break | input | 1 | Forces the line low |
| cfg_rx_isel | input | 2 | Receive interrupt condition (R11) |
| cfg_tx_isel | input | 2 | Transmit interrupt condition (R12) |
| cfg_divisor | input | 16 | Bit time = 16*(value+1) cycles |
| tx_push | input | 1 | Writes `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Character to queue |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | FIFO and shifter both empty |
| rx_pop | input | 1 | Removes the receive head |
| rx_data | output | 8 | Receive head character |
| rx_avail | output | 1 | Receive FIFO not empty |
| rx_par_err | output | 1 | Head has a parity error |
| rx_frm_err | output | 1 | Head has a framing error |
| rx_overrun | output | 1 | Sticky overrun flag |
| ovr_clear | input | 1 | Clears overrun and flushes the receive FIFO |
| serial_rx | input | 1 | Serial input line |
| serial_tx | output | 1 | Serial output line |
| irq_fault | output | 1 | Overrun or head error |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The assertions assume that reset is held for at least one clock and that `ovr_clear` and the strobes are sampled on rising edges. The overrun hold property also assumes that `cfg_on` stays 1 over the cycles it watches. The stimulus keeps the divisor fixed within each run of frames. It changes configuration fields only while the transmitter is idle, or just before a flush by dropping `cfg_on`. It drives `serial_rx` with whole bit periods that match the programmed divisor, so every frame the receiver sees is aligned to a full bit time.

// File: rtl/uart_pkg.sv
package uart_pkg;

  localparam int DATA_W   = 8;
  localparam int OS_RATE  = 16;
  localparam int OS_W     = $clog2(OS_RATE);
  localparam int BIT_W    = $clog2(DATA_W);

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT
  } rx_state_e;

  typedef struct packed {
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_word_t;

  function automatic logic parity_on(input logic [1:0] sel);
    return (sel == PAR_EVEN) || (sel == PAR_ODD);
  endfunction

  function automatic logic parity_bit(input logic [DATA_W-1:0] d,
                                      input logic [1:0] sel);
    return (sel == PAR_ODD) ? ~(^d) : (^d);
  endfunction

endpackage

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [$clog2(DEPTH):0] count,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  // storage has no reset so it maps onto RAM resources
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> $stable(count));

  // R6
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !flush) |=> (count == '0));

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= divisor) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              tx_en,
  input  logic              tick,
  input  logic [1:0]        parity_sel,
  input  logic              two_stop,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              line,
  output logic              busy
);
  localparam logic [OS_W-1:0]  SC_LAST  = OS_W'(OS_RATE - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  tx_state_e         state;
  logic [OS_W-1:0]   sc;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;
  logic              par_q, stop2, frame_end;

  assign busy      = (state != TX_IDLE);
  assign frame_end = (state == TX_STOP) && (sc == SC_LAST) && (!two_stop || stop2);
  assign fifo_pop  = enable && tick && tx_en && !fifo_empty &&
                     ((state == TX_IDLE) || frame_end);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state <= TX_IDLE;
      line  <= 1'b1;
      sc    <= '0;
      bitn  <= '0;
      shreg <= '0;
      par_q <= 1'b0;
      stop2 <= 1'b0;
    end else if (tick) begin
      if (fifo_pop) begin
        state <= TX_START;
        line  <= 1'b0;
        sc    <= '0;
        shreg <= fifo_data;
        par_q <= parity_bit(fifo_data, parity_sel);
        stop2 <= 1'b0;
      end else if (state != TX_IDLE) begin
        sc <= sc + 1'b1;
        if (sc == SC_LAST) begin
          case (state)
            TX_START: begin
              state <= TX_DATA;
              line  <= shreg[0];
              bitn  <= '0;
            end
            TX_DATA: begin
              if (bitn == BIT_LAST) begin
                if (parity_on(parity_sel)) begin
                  state <= TX_PAR;
                  line  <= par_q;
                end else begin
                  state <= TX_STOP;
                  line  <= 1'b1;
                end
              end else begin
                bitn  <= bitn + 1'b1;
                shreg <= shreg >> 1;
                line  <= shreg[1];
              end
            end
            TX_PAR: begin
              state <= TX_STOP;
              line  <= 1'b1;
            end
            TX_STOP: begin
              if (two_stop && !stop2) stop2 <= 1'b1;
              else                    state <= TX_IDLE;
            end
            default: state <= TX_IDLE;
          endcase
        end
      end
    end
  end

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    (state == TX_IDLE) |-> line);

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       tick,
  input  logic       line_in,
  input  logic [1:0] parity_sel,
  output logic       word_valid,
  output rx_word_t   word
);
  localparam logic [OS_W-1:0]  SC_MID   = OS_W'(OS_RATE / 2 - 1);
  localparam logic [OS_W-1:0]  SC_LAST  = OS_W'(OS_RATE - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  rx_state_e         state;
  logic [OS_W-1:0]   sc;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;
  logic              par_err;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state      <= RX_IDLE;
      sc         <= '0;
      bitn       <= '0;
      shreg      <= '0;
      par_err    <= 1'b0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (state == RX_WAIT) begin
        if (line_in) state <= RX_IDLE;
      end else if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!line_in) begin
              state <= RX_START;
              sc    <= '0;
            end
          end
          RX_START: begin
            sc <= sc + 1'b1;
            if (sc == SC_MID) begin
              sc <= '0;
              if (!line_in) begin
                state   <= RX_DATA;
                bitn    <= '0;
                par_err <= 1'b0;
              end else begin
                state <= RX_IDLE;
              end
            end
          end
          RX_DATA: begin
            sc <= sc + 1'b1;
            if (sc == SC_LAST) begin
              shreg <= {line_in, shreg[DATA_W-1:1]};
              bitn  <= bitn + 1'b1;
              if (bitn == BIT_LAST)
                state <= parity_on(parity_sel) ? RX_PAR : RX_STOP;
            end
          end
          RX_PAR: begin
            sc <= sc + 1'b1;
            if (sc == SC_LAST) begin
              par_err <= (line_in != parity_bit(shreg, parity_sel));
              state   <= RX_STOP;
            end
          end
          RX_STOP: begin
            sc <= sc + 1'b1;
            if (sc == SC_LAST) begin
              word_valid <= 1'b1;
              word       <= '{frm: !line_in, par: par_err, data: shreg};
              state      <= line_in ? RX_IDLE : RX_WAIT;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R8
  frame_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word.frm) |-> (state == RX_WAIT));

endmodule

// File: rtl/uart_fifo_core.sv
module uart_fifo_core
  import uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_on,
  input  logic              cfg_tx_en,
  input  logic              cfg_rx_en,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_two_stop,
  input  logic              cfg_loopback,
  input  logic              cfg_break,
  input  logic [1:0]        cfg_rx_isel,
  input  logic [1:0]        cfg_tx_isel,
  input  logic [DIV_W-1:0]  cfg_divisor,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_avail,
  output logic              rx_par_err,
  output logic              rx_frm_err,
  output logic              rx_overrun,
  input  logic              ovr_clear,
  input  logic              serial_rx,
  output logic              serial_tx,
  output logic              irq_fault,
  output logic              irq_rx,
  output logic              irq_tx
);
  localparam int CW       = $clog2(FIFO_DEPTH) + 1;
  localparam int RXW      = $bits(rx_word_t);
  localparam logic [CW-1:0] HALF = CW'(FIFO_DEPTH / 2);
  localparam logic [CW-1:0] FULL = CW'(FIFO_DEPTH);

  logic              tick;
  logic              txf_pop, txf_full, txf_empty;
  logic [DATA_W-1:0] txf_head;
  logic [CW-1:0]     txf_count;
  logic              tx_line, tx_busy;
  logic [1:0]        rx_sync;
  logic              rx_src;
  logic              rw_valid;
  rx_word_t          rw_word;
  logic              rxf_push, rxf_full, rxf_empty, rxf_flush;
  logic [RXW-1:0]    rxf_head_bits;
  rx_word_t          rxf_head;
  logic [CW-1:0]     rxf_count;
  logic              ovr_q;

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .enable(cfg_on), .divisor(cfg_divisor), .tick(tick)
  );

  uart_sync_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst(rst), .flush(!cfg_on), .push(tx_push), .wdata(tx_data),
    .pop(txf_pop), .rdata(txf_head), .count(txf_count),
    .full(txf_full), .empty(txf_empty)
  );

  uart_tx_engine u_tx (
    .clk(clk), .rst(rst), .enable(cfg_on), .tx_en(cfg_tx_en), .tick(tick),
    .parity_sel(cfg_parity), .two_stop(cfg_two_stop),
    .fifo_empty(txf_empty), .fifo_data(txf_head), .fifo_pop(txf_pop),
    .line(tx_line), .busy(tx_busy)
  );

  // output line register: off forces idle, break forces low
  always_ff @(posedge clk) begin
    if (rst || !cfg_on)  serial_tx <= 1'b1;
    else if (cfg_break)  serial_tx <= 1'b0;
    else                 serial_tx <= tx_line;
  end

  // receive source select and two-stage synchronizer
  assign rx_src = cfg_loopback ? serial_tx : serial_rx;

  always_ff @(posedge clk) begin
    if (rst) rx_sync <= 2'b11;
    else     rx_sync <= {rx_sync[0], rx_src};
  end

  uart_rx_engine u_rx (
    .clk(clk), .rst(rst), .enable(cfg_on), .tick(tick), .line_in(rx_sync[1]),
    .parity_sel(cfg_parity), .word_valid(rw_valid), .word(rw_word)
  );

  assign rxf_push  = rw_valid && cfg_rx_en;
  assign rxf_flush = !cfg_on || ovr_clear;

  uart_sync_fifo #(.WIDTH(RXW), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst(rst), .flush(rxf_flush), .push(rxf_push), .wdata(rw_word),
    .pop(rx_pop), .rdata(rxf_head_bits), .count(rxf_count),
    .full(rxf_full), .empty(rxf_empty)
  );

  assign rxf_head = rx_word_t'(rxf_head_bits);

  always_ff @(posedge clk) begin
    if (rst || rxf_flush)         ovr_q <= 1'b0;
    else if (rxf_push && rxf_full) ovr_q <= 1'b1;
  end

  assign tx_full    = txf_full;
  assign tx_empty   = txf_empty && !tx_busy;
  assign rx_avail   = !rxf_empty;
  assign rx_data    = rxf_head.data;
  assign rx_par_err = rx_avail && rxf_head.par;
  assign rx_frm_err = rx_avail && rxf_head.frm;
  assign rx_overrun = ovr_q;

  // registered interrupt lines
  always_ff @(posedge clk) begin
    if (rst || !cfg_on) begin
      irq_fault <= 1'b0;
      irq_rx    <= 1'b0;
      irq_tx    <= 1'b0;
    end else begin
      irq_fault <= ovr_q || rx_par_err || rx_frm_err;
      case (cfg_rx_isel)
        2'b00:   irq_rx <= (rxf_count != '0);
        2'b01:   irq_rx <= (rxf_count >= HALF);
        default: irq_rx <= (rxf_count == FULL);
      endcase
      case (cfg_tx_isel)
        2'b00:   irq_tx <= !txf_full;
        2'b01:   irq_tx <= txf_empty && !tx_busy;
        default: irq_tx <= txf_empty;
      endcase
    end
  end

  // R10
  break_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_on && cfg_break) |=> !serial_tx);

  // R13
  off_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_on |=> (serial_tx && (txf_count == '0) && (rxf_count == '0)));

  // R5
  empty_not_full_chk: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> !tx_full);

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !ovr_clear && cfg_on) |=> rx_overrun);

  // R14
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_tx_en && !tx_busy) |=> !tx_busy);

endmodule

// File: tb/tb_uart_fifo_core.sv
`timescale 1ns/1ps
module tb_uart_fifo_core;
  localparam int P = 32; // bit time for divisor 1: 16*(1+1)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_on = 0, cfg_tx_en = 0, cfg_rx_en = 0, cfg_two_stop = 0;
  logic cfg_loopback = 0, cfg_break = 0;
  logic [1:0] cfg_parity = 0, cfg_rx_isel = 0, cfg_tx_isel = 0;
  logic [15:0] cfg_divisor = 16'd1;
  logic tx_push = 0, rx_pop = 0, ovr_clear = 0, serial_rx = 1;
  logic [7:0] tx_data = 0;
  logic tx_full, tx_empty, rx_avail, rx_par_err, rx_frm_err, rx_overrun;
  logic serial_tx, irq_fault, irq_rx, irq_tx;
  logic [7:0] rx_data;

  int total = 0, bad = 0, cyc = 0, seed_init;

  always #2.5 clk = ~clk;

  uart_fifo_core dut (
    .clk(clk), .rst(rst), .cfg_on(cfg_on), .cfg_tx_en(cfg_tx_en),
    .cfg_rx_en(cfg_rx_en), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .cfg_loopback(cfg_loopback), .cfg_break(cfg_break), .cfg_rx_isel(cfg_rx_isel),
    .cfg_tx_isel(cfg_tx_isel), .cfg_divisor(cfg_divisor), .tx_push(tx_push),
    .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_avail(rx_avail), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_overrun(rx_overrun), .ovr_clear(ovr_clear),
    .serial_rx(serial_rx), .serial_tx(serial_tx), .irq_fault(irq_fault),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog (R1..all) actual=%0d expected<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] sel);
    return (sel == 2'b10) ? ~(^d) : (^d);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    tx_push = 1; tx_data = b; tk(1); tx_push = 0;
  endtask

  task automatic pop();
    rx_pop = 1; tk(1); rx_pop = 0;
  endtask

  task automatic restart();
    cfg_on = 0; tk(4); cfg_on = 1; tk(2);
  endtask

  task automatic wait_line(input logic lvl);
    int n = 0;
    while (serial_tx !== lvl && n < 5000) begin tk(1); n++; end
  endtask

  task automatic wait_tx_idle();
    int n = 0;
    while (tx_empty !== 1'b1 && n < 20000) begin tk(1); n++; end
    tk(40);
  endtask

  task automatic drive_frame(input logic [7:0] d, input logic par_on,
                             input logic par_v, input logic stop_v);
    serial_rx = 0; tk(P);
    for (int i = 0; i < 8; i++) begin serial_rx = d[i]; tk(P); end
    if (par_on) begin serial_rx = par_v; tk(P); end
    serial_rx = stop_v; tk(P);
    serial_rx = 1; tk(P);
  endtask

  task automatic capture(input logic par_on, output logic [7:0] d,
                         output logic p, output logic s);
    wait_line(1'b0);
    tk(P/2);
    for (int i = 0; i < 8; i++) begin tk(P); d[i] = serial_tx; end
    p = 1'b0;
    if (par_on) begin tk(P); p = serial_tx; end
    tk(P); s = serial_tx;
  endtask

  initial begin
    logic [7:0] q [8];
    logic [7:0] d;
    logic p, s;
    int n, cnt;
    logic [7:0] last;

    seed_init = $urandom(32'd7351);
    tk(5);
    rst = 0;
    tk(2);
    // R1 reset state
    chk("R1", "serial_tx", serial_tx, 1);
    chk("R1", "tx_empty", tx_empty, 1);
    chk("R1", "tx_full", tx_full, 0);
    chk("R1", "rx_avail", rx_avail, 0);
    chk("R1", "rx_overrun", rx_overrun, 0);
    chk("R1", "irqs", {irq_fault, irq_rx, irq_tx}, 0);

    cfg_on = 1; cfg_tx_en = 1; cfg_rx_en = 1; cfg_loopback = 1; serial_rx = 0;
    tk(2);

    // R2 start bit lasts one bit time
    push(8'h01);
    wait_line(1'b0);
    n = 0;
    while (serial_tx === 1'b0 && n < 1000) begin tk(1); n++; end
    chk("R2", "start bit length", n, P);
    wait_tx_idle(); restart();

    // R2 / R3 frame contents under every parity mode
    for (int m = 0; m < 3; m++) begin
      cfg_parity = 2'(m);
      foreach (q[k]) q[k] = 0;
      for (int b = 0; b < 2; b++) begin
        logic [7:0] v;
        v = (b == 0) ? 8'hA5 : 8'h3C;
        push(v);
        capture(m != 0, d, p, s);
        chk("R2", "data bits", d, v);
        chk("R2", "stop level", s, 1);
        if (m != 0) chk("R3", "parity bit", p, exp_par(v, 2'(m)));
        wait_tx_idle();
      end
    end
    cfg_parity = 0; restart();

    // R2 stop-bit count seen as idle-high gap between two zero bytes
    for (int t = 1; t >= 0; t--) begin
      cfg_two_stop = t[0];
      push(8'h00); push(8'h00);
      wait_line(1'b0);
      wait_line(1'b1);
      n = 0;
      while (serial_tx === 1'b1 && n < 1000) begin tk(1); n++; end
      chk("R2", "stop gap", n, (t == 1) ? 2*P : P);
      wait_tx_idle();
    end
    cfg_two_stop = 0; restart();

    // R6 / R9 random traffic through loopback, serial_rx held low
    for (int it = 0; it < 6; it++) begin
      cfg_parity = 2'($urandom % 3);
      cfg_two_stop = $urandom % 2;
      restart();
      n = 1 + ($urandom % 8);
      for (int k = 0; k < n; k++) begin q[k] = 8'($urandom); push(q[k]); end
      wait_tx_idle();
      for (int k = 0; k < n; k++) begin
        chk("R6", "rx_avail", rx_avail, 1);
        chk("R9", "loopback data", rx_data, q[k]);
        chk("R8", "clean flags", {rx_par_err, rx_frm_err}, 0);
        pop();
      end
      chk("R6", "drained", rx_avail, 0);
    end
    cfg_parity = 0; cfg_two_stop = 0;

    // R4 / R14 / R12 full transmit FIFO while tx disabled
    restart();
    cfg_tx_en = 0; cfg_tx_isel = 2'b10;
    for (int k = 0; k < 9; k++) push(8'h40 + 8'(k));
    tk(100);
    chk("R4", "tx_full", tx_full, 1);
    chk("R5", "tx_empty while queued", tx_empty, 0);
    chk("R12", "irq_tx fifo-empty sel", irq_tx, 0);
    chk("R14", "line idle with tx off", serial_tx, 1);
    cfg_tx_en = 1;
    wait_tx_idle();
    cnt = 0; last = 0;
    while (rx_avail === 1'b1 && cnt < 20) begin last = rx_data; pop(); cnt++; end
    chk("R4", "chars kept", cnt, 8);
    chk("R4", "last char", last, 8'h47);

    // R5 / R12 transmit-empty versus FIFO-empty
    restart();
    cfg_tx_isel = 2'b01;
    push(8'h55);
    tk(3*P);
    chk("R5", "tx_empty during shift", tx_empty, 0);
    chk("R12", "irq_tx all-sent sel", irq_tx, 0);
    cfg_tx_isel = 2'b10; tk(2);
    chk("R12", "irq_tx fifo-empty sel", irq_tx, 1);
    cfg_tx_isel = 2'b01;
    wait_tx_idle();
    chk("R5", "tx_empty after frame", tx_empty, 1);
    chk("R12", "irq_tx all-sent", irq_tx, 1);
    cfg_tx_isel = 0;

    // R11 receive interrupt thresholds
    restart();
    cfg_rx_isel = 2'b01;
    for (int k = 0; k < 3; k++) push(8'h10 + 8'(k));
    wait_tx_idle();
    chk("R11", "irq_rx below half", irq_rx, 0);
    push(8'h13); wait_tx_idle();
    chk("R11", "irq_rx at half", irq_rx, 1);
    cfg_rx_isel = 2'b00;
    pop(); pop(); pop(); tk(2);
    chk("R11", "irq_rx any", irq_rx, 1);
    cfg_rx_isel = 2'b01; tk(2);
    chk("R11", "irq_rx one left half sel", irq_rx, 0);
    cfg_rx_isel = 2'b00; pop(); tk(2);
    chk("R11", "irq_rx none", irq_rx, 0);

    // R7 overrun sticky and clear flushes
    restart();
    for (int k = 0; k < 8; k++) push(8'h80 + 8'(k));
    wait_tx_idle();
    chk("R7", "no overrun at full", rx_overrun, 0);
    push(8'h99); wait_tx_idle();
    chk("R7", "overrun set", rx_overrun, 1);
    chk("R7", "irq_fault", irq_fault, 1);
    chk("R7", "head kept", rx_data, 8'h80);
    tk(50);
    chk("R7", "overrun sticky", rx_overrun, 1);
    ovr_clear = 1; tk(1); ovr_clear = 0; tk(2);
    chk("R7", "overrun cleared", rx_overrun, 0);
    chk("R7", "rx flushed", rx_avail, 0);
    chk("R7", "irq_fault cleared", irq_fault, 0);

    // R8 error flags follow the head
    serial_rx = 1; cfg_loopback = 0; cfg_parity = 2'b01;
    restart(); tk(P);
    drive_frame(8'h3C, 1, ~exp_par(8'h3C, 2'b01), 1);
    drive_frame(8'h11, 1, exp_par(8'h11, 2'b01), 1);
    drive_frame(8'h22, 1, exp_par(8'h22, 2'b01), 0);
    tk(4);
    chk("R8", "head0 data", rx_data, 8'h3C);
    chk("R8", "head0 flags", {rx_par_err, rx_frm_err}, 2'b10);
    chk("R8", "head0 irq_fault", irq_fault, 1);
    pop(); tk(2);
    chk("R8", "head1 data", rx_data, 8'h11);
    chk("R8", "head1 flags", {rx_par_err, rx_frm_err}, 2'b00);
    chk("R8", "head1 irq_fault", irq_fault, 0);
    pop(); tk(2);
    chk("R8", "head2 data", rx_data, 8'h22);
    chk("R8", "head2 flags", {rx_par_err, rx_frm_err}, 2'b01);
    pop();

    // R14 receiver disabled drops characters
    restart();
    cfg_rx_en = 0;
    drive_frame(8'h5A, 1, exp_par(8'h5A, 2'b01), 1);
    tk(4);
    chk("R14", "rx disabled", rx_avail, 0);
    cfg_rx_en = 1; cfg_parity = 0;

    // R10 break
    cfg_break = 1; tk(3);
    chk("R10", "break low", serial_tx, 0);
    cfg_break = 0; tk(3);
    chk("R10", "break released", serial_tx, 1);

    // R13 disable flushes and idles
    cfg_loopback = 1; restart();
    push(8'h61); push(8'h62); wait_tx_idle();
    cfg_tx_en = 0;
    push(8'h63); push(8'h64); push(8'h65);
    chk("R13", "queued before off", tx_empty, 0);
    cfg_on = 0; tk(3);
    chk("R13", "tx flushed", tx_empty, 1);
    chk("R13", "rx flushed", rx_avail, 0);
    chk("R13", "line high", serial_tx, 1);
    chk("R13", "irqs low", {irq_fault, irq_rx, irq_tx}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule